// File: doc/BRIEF.md
# Triangle-Carrier Complementary PWM Generator

The block drives three phase legs of a power stage. One up/down carrier counter makes a triangle. For each phase, a compare against a working duty value sets the wanted level of the leg. Two non-overlapping outputs are derived from that level: a high-side (positive) output and a low-side (negative) output. A programmable dead band of idle cycles separates every hand-over between them.

Software writes duty values into first-level buffers. The working values change only at defined transfer points, so no PWM period ever uses a half-updated set. A transfer point is either every carrier crest and trough, or the cycle after a write to the last phase's duty register. An optional second buffer stage delays each update by one more transfer point.

Crest and trough interrupt pulses can be thinned by independent skip counts. An A/D start pulse is placed on the falling slope of the carrier at a programmable value, and it is thinned together with the trough interrupt.

Top module: `cpwm_gen`

## Requirements
- R1: After reset, every output (`pwm_pos`, `pwm_neg`, `crest_irq`, `trough_irq`, `adc_trig`) is 0 and the carrier is stopped.
- R2: While running, the carrier starts at the dead-band value and steps up by one per cycle up to the period value (crest). It then steps down to 0 (trough), then up again from 1. `crest_irq` and `trough_irq` are one-cycle pulses in the cycle after the carrier sits at the crest or the trough.
- R3: For phase i, the wanted leg level is high in a cycle when the carrier is strictly greater than the working duty of that phase. The outputs follow that level one cycle later, subject to R4.
- R4: When a phase's wanted level changes, or in the first running cycle, both outputs of that phase are low for exactly D cycles, where D is the dead-band register. Then the output that matches the new level goes high (positive for high, negative for low). With D = 0 the hand-over takes effect directly. Both outputs are never high together while running.
- R5: In single-buffer mode, each transfer point copies the first buffer to the working duty, which becomes active in the next cycle.
- R6: In double-buffer mode (control bit 1), each transfer point copies the second buffer to the working duty and the first buffer to the second buffer. A written value therefore becomes active one transfer point later than in R5.
- R7: With control bit 4 set, crests and troughs are no transfer points. Instead, the cycle after a write to the last duty address (7) is a transfer point.
- R8: The crest skip count N (skip register bits 2:0) lets the first crest after start through. After each passed crest, the next N crests are suppressed.
- R9: The trough skip count M (skip register bits 5:3) thins troughs in the same way as R8.
- R10: `adc_trig` pulses in the cycle after a cycle in which the carrier counts down and equals the A/D compare register, but only while the trough skip counter would let the coming trough through.
- R11: While control bit 0 (run) is 0, all positive outputs equal control bit 2 and all negative outputs equal control bit 3. This takes effect one cycle after the write. While stopped, the working duties follow the first buffers.
- R12: Register addresses: 0 control {bit4 write-triggered transfer, bit3 negative idle level, bit2 positive idle level, bit1 double buffer, bit0 run}, 1 period, 2 dead band, 3 A/D compare, 4 skip counts, 5+i duty of phase i. A write takes effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| pwm_pos | output | 3 | Positive-phase outputs, bit i = phase i |
| pwm_neg | output | 3 | Negative-phase outputs, bit i = phase i |
| crest_irq | output | 1 | Crest interrupt pulse |
| trough_irq | output | 1 | Trough interrupt pulse |
| adc_trig | output | 1 | A/D start pulse |

## Verification
The phase outputs are compared cycle by cycle against an arithmetic carrier model. The sweep covers every dead band from 0 to 3, both buffer depths, and duties at 0, inside the range and at the period, so both always-high and always-low legs appear. Duties change in mid-run, which separates single-buffer updates from double-buffer updates by the transfer point at which a new edge position appears. All eight splits of the skip counts between crest and trough are tried, and the pulse totals are checked against a closed-form ceiling, which tells the two skip fields apart and ties the A/D pulse to the trough gate. A write-triggered run shows that crests no longer move duties. The idle-level walk confirms that each level bit reaches its own output group.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
    localparam int unsigned SKW      = 3;
    localparam int unsigned A_CTRL   = 0;
    localparam int unsigned A_PERIOD = 1;
    localparam int unsigned A_DEAD   = 2;
    localparam int unsigned A_ADC    = 3;
    localparam int unsigned A_SKIP   = 4;
    localparam int unsigned A_DUTY0  = 5;

    typedef struct packed {
        logic xfer_wr;
        logic idle_n;
        logic idle_p;
        logic dbl;
        logic run;
    } ctrl_t;
endpackage

// File: rtl/cpwm_carrier.sv
module cpwm_carrier #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [CW-1:0] period,
    input  logic [CW-1:0] dead,
    output logic [CW-1:0] cnt,
    output logic          up,
    output logic          crest,
    output logic          trough
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          up;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        crest  = run && st_q.up && (st_q.cnt >= period);
        trough = run && !st_q.up && (st_q.cnt == '0);
        if (!run) begin
            st_d.cnt = dead;
            st_d.up  = 1'b1;
        end else if (crest) begin
            st_d.up  = 1'b0;
            st_d.cnt = st_q.cnt - 1'b1;
        end else if (trough) begin
            st_d.up  = 1'b1;
            st_d.cnt = CW'(1);
        end else if (st_q.up) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end else begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{cnt: '0, up: 1'b1};
        else        st_q <= st_d;
    end

    assign cnt = st_q.cnt;
    assign up  = st_q.up;

    // R2: the carrier turns downward right after a crest
    a_r2_crest_turn: assert property (@(posedge clk) disable iff (!rst_n)
        crest |=> (cnt == $past(cnt) - 1'b1));
    // R2: after a trough the carrier restarts at one
    a_r2_trough_turn: assert property (@(posedge clk) disable iff (!rst_n)
        trough |=> (cnt == CW'(1)));
endmodule

// File: rtl/cpwm_dutybuf.sv
module cpwm_dutybuf #(
    parameter int CW  = 8,
    parameter int NPH = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    run,
    input  logic                    dbl,
    input  logic                    tp,
    input  logic [NPH-1:0]          wr_hit,
    input  logic [CW-1:0]           wr_data,
    output logic [NPH-1:0][CW-1:0]  work
);
    typedef struct packed {
        logic [NPH-1:0][CW-1:0] b1;
        logic [NPH-1:0][CW-1:0] b2;
        logic [NPH-1:0][CW-1:0] wk;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NPH; i++) begin
            if (wr_hit[i]) st_d.b1[i] = wr_data;
        end
        if (!run) begin
            st_d.b2 = st_q.b1;
            st_d.wk = st_q.b1;
        end else if (tp) begin
            if (dbl) begin
                st_d.b2 = st_q.b1;
                st_d.wk = st_q.b2;
            end else begin
                st_d.wk = st_q.b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign work = st_q.wk;

    // R5: working duties move only at transfer points while running
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(run) && !$past(tp)) |-> $stable(st_q.wk));
    // R6: double buffer hands over the second stage
    a_r6_second: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(run) && $past(tp) && $past(dbl)) |-> (st_q.wk == $past(st_q.b2)));
endmodule

// File: rtl/cpwm_deadband.sv
module cpwm_deadband #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          raw,
    input  logic [CW-1:0] dead,
    input  logic          idle_p,
    input  logic          idle_n,
    output logic          pos,
    output logic          neg
);
    typedef struct packed {
        logic          lvl;
        logic          armed;
        logic [CW-1:0] dcnt;
        logic          pos;
        logic          neg;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!run) begin
            st_d.armed = 1'b0;
            st_d.lvl   = 1'b0;
            st_d.dcnt  = '0;
            st_d.pos   = idle_p;
            st_d.neg   = idle_n;
        end else if (!st_q.armed || (raw != st_q.lvl)) begin
            st_d.armed = 1'b1;
            st_d.lvl   = raw;
            st_d.dcnt  = '0;
            st_d.pos   = (dead == '0) ? raw  : 1'b0;
            st_d.neg   = (dead == '0) ? !raw : 1'b0;
        end else if (({1'b0, st_q.dcnt} + 1'b1) >= {1'b0, dead}) begin
            st_d.pos = st_q.lvl;
            st_d.neg = !st_q.lvl;
        end else begin
            st_d.dcnt = st_q.dcnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pos = st_q.pos;
    assign neg = st_q.neg;

    // R4: the two legs never conduct together while running
    a_r4_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        $past(run) |-> !(pos && neg));
    // R11: stopped outputs show the idle levels
    a_r11_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(run) |-> (pos == $past(idle_p) && neg == $past(idle_n)));
endmodule

// File: rtl/cpwm_events.sv
module cpwm_events #(
    parameter int CW = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      run,
    input  logic                      up,
    input  logic [CW-1:0]             cnt,
    input  logic                      crest,
    input  logic                      trough,
    input  logic [CW-1:0]             adc_cmp,
    input  logic [cpwm_pkg::SKW-1:0]  skip_c,
    input  logic [cpwm_pkg::SKW-1:0]  skip_t,
    output logic                      crest_irq,
    output logic                      trough_irq,
    output logic                      adc_trig
);
    import cpwm_pkg::*;

    typedef struct packed {
        logic [SKW-1:0] skc;
        logic [SKW-1:0] skt;
        logic           ci;
        logic           ti;
        logic           at;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.ci = 1'b0;
        st_d.ti = 1'b0;
        st_d.at = run && !up && (cnt == adc_cmp) && (st_q.skt == '0);
        if (!run) begin
            st_d.skc = '0;
            st_d.skt = '0;
        end else begin
            if (crest) begin
                st_d.ci  = (st_q.skc == '0);
                st_d.skc = (st_q.skc == '0) ? skip_c : st_q.skc - 1'b1;
            end
            if (trough) begin
                st_d.ti  = (st_q.skt == '0);
                st_d.skt = (st_q.skt == '0) ? skip_t : st_q.skt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign crest_irq  = st_q.ci;
    assign trough_irq = st_q.ti;
    assign adc_trig   = st_q.at;

    // R8: a crest pulse always follows a crest
    a_r8_crest_src: assert property (@(posedge clk) disable iff (!rst_n)
        crest_irq |-> $past(crest));
    // R9: a trough pulse always follows a trough
    a_r9_trough_src: assert property (@(posedge clk) disable iff (!rst_n)
        trough_irq |-> $past(trough));
    // R10: A/D pulse only after a down-slope compare hit
    a_r10_adc_src: assert property (@(posedge clk) disable iff (!rst_n)
        adc_trig |-> $past(run && !up && cnt == adc_cmp));
endmodule

// File: rtl/cpwm_gen.sv
module cpwm_gen #(
    parameter  int CW  = 8,
    parameter  int NPH = 3,
    localparam int AW  = $clog2(cpwm_pkg::A_DUTY0 + NPH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [AW-1:0]  wr_addr,
    input  logic [CW-1:0]  wr_data,
    output logic [NPH-1:0] pwm_pos,
    output logic [NPH-1:0] pwm_neg,
    output logic           crest_irq,
    output logic           trough_irq,
    output logic           adc_trig
);
    import cpwm_pkg::*;

    typedef struct packed {
        ctrl_t          ctrl;
        logic [CW-1:0]  period;
        logic [CW-1:0]  dead;
        logic [CW-1:0]  adc_cmp;
        logic [SKW-1:0] skip_c;
        logic [SKW-1:0] skip_t;
        logic           wrote;
    } regs_t;

    regs_t rg_d, rg_q;

    always_comb begin
        rg_d       = rg_q;
        rg_d.wrote = wr_en && (wr_addr == AW'(A_DUTY0 + NPH - 1));
        if (wr_en) begin
            case (int'(wr_addr))
                A_CTRL:   rg_d.ctrl    = ctrl_t'(wr_data[$bits(ctrl_t)-1:0]);
                A_PERIOD: rg_d.period  = wr_data;
                A_DEAD:   rg_d.dead    = wr_data;
                A_ADC:    rg_d.adc_cmp = wr_data;
                A_SKIP: begin
                    rg_d.skip_c = wr_data[SKW-1:0];
                    rg_d.skip_t = wr_data[2*SKW-1:SKW];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rg_q <= '0;
        else        rg_q <= rg_d;
    end

    logic [CW-1:0]          cnt;
    logic                   up, crest, trough, tp;
    logic [NPH-1:0]         wr_hit;
    logic [NPH-1:0][CW-1:0] work;

    cpwm_carrier #(.CW(CW)) u_car (
        .clk(clk), .rst_n(rst_n), .run(rg_q.ctrl.run),
        .period(rg_q.period), .dead(rg_q.dead),
        .cnt(cnt), .up(up), .crest(crest), .trough(trough)
    );

    assign tp = rg_q.ctrl.xfer_wr ? rg_q.wrote : (crest || trough);

    for (genvar i = 0; i < NPH; i++) begin : g_ph
        assign wr_hit[i] = wr_en && (wr_addr == AW'(A_DUTY0 + i));

        cpwm_deadband #(.CW(CW)) u_db (
            .clk(clk), .rst_n(rst_n), .run(rg_q.ctrl.run),
            .raw(cnt > work[i]), .dead(rg_q.dead),
            .idle_p(rg_q.ctrl.idle_p), .idle_n(rg_q.ctrl.idle_n),
            .pos(pwm_pos[i]), .neg(pwm_neg[i])
        );
    end

    cpwm_dutybuf #(.CW(CW), .NPH(NPH)) u_buf (
        .clk(clk), .rst_n(rst_n), .run(rg_q.ctrl.run), .dbl(rg_q.ctrl.dbl),
        .tp(tp), .wr_hit(wr_hit), .wr_data(wr_data), .work(work)
    );

    cpwm_events #(.CW(CW)) u_evt (
        .clk(clk), .rst_n(rst_n), .run(rg_q.ctrl.run), .up(up), .cnt(cnt),
        .crest(crest), .trough(trough), .adc_cmp(rg_q.adc_cmp),
        .skip_c(rg_q.skip_c), .skip_t(rg_q.skip_t),
        .crest_irq(crest_irq), .trough_irq(trough_irq), .adc_trig(adc_trig)
    );

    // R7: in write-triggered mode a crest alone never moves duties
    a_r7_no_crest_xfer: assert property (@(posedge clk) disable iff (!rst_n)
        (rg_q.ctrl.xfer_wr && crest && !rg_q.wrote) |-> !tp);
endmodule

// File: tb/tb_cpwm_gen.sv
`timescale 1ns/1ps
module tb_cpwm_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] pwm_pos, pwm_neg;
    logic       crest_irq, trough_irq, adc_trig;

    always #2.5 clk = ~clk;

    cpwm_gen dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .pwm_pos(pwm_pos), .pwm_neg(pwm_neg),
        .crest_irq(crest_irq), .trough_irq(trough_irq), .adc_trig(adc_trig)
    );

    int n_tests = 0, n_fail = 0;
    bit done = 0;

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // ---------------- spec model ----------------
    logic [4:0] m_ctrl;
    logic [7:0] m_per, m_dead, m_adc, m_cnt;
    logic [2:0] m_skcfg_c, m_skcfg_t, m_skc, m_skt;
    logic       m_up, m_wrote, m_ci, m_ti, m_at;
    logic [7:0] m_b1 [3], m_b2 [3], m_wk [3];
    logic [2:0] m_lvl, m_arm, m_pos, m_neg;
    int         m_dc [3];
    logic       t_run, t_crest, t_trough, t_tp, t_raw;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ctrl = '0; m_per = '0; m_dead = '0; m_adc = '0; m_cnt = '0; m_up = 1;
            m_skcfg_c = '0; m_skcfg_t = '0; m_skc = '0; m_skt = '0; m_wrote = 0;
            m_ci = 0; m_ti = 0; m_at = 0; m_lvl = '0; m_arm = '0; m_pos = '0; m_neg = '0;
            for (int i = 0; i < 3; i++) begin m_b1[i] = '0; m_b2[i] = '0; m_wk[i] = '0; m_dc[i] = 0; end
        end else begin
            t_run    = m_ctrl[0];
            t_crest  = t_run && m_up && (m_cnt >= m_per);
            t_trough = t_run && !m_up && (m_cnt == 0);
            t_tp     = m_ctrl[4] ? m_wrote : (t_crest || t_trough);
            m_at     = t_run && !m_up && (m_cnt == m_adc) && (m_skt == 0);
            m_ci = 0; m_ti = 0;
            if (!t_run) begin m_skc = 0; m_skt = 0; end
            else begin
                if (t_crest) begin m_ci = (m_skc == 0); m_skc = (m_skc == 0) ? m_skcfg_c : m_skc - 1; end
                if (t_trough) begin m_ti = (m_skt == 0); m_skt = (m_skt == 0) ? m_skcfg_t : m_skt - 1; end
            end
            for (int i = 0; i < 3; i++) begin
                t_raw = (m_cnt > m_wk[i]);
                if (!t_run) begin
                    m_arm[i] = 0; m_lvl[i] = 0; m_dc[i] = 0; m_pos[i] = m_ctrl[2]; m_neg[i] = m_ctrl[3];
                end else if (!m_arm[i] || t_raw != m_lvl[i]) begin
                    m_arm[i] = 1; m_lvl[i] = t_raw; m_dc[i] = 0;
                    m_pos[i] = (m_dead == 0) && t_raw; m_neg[i] = (m_dead == 0) && !t_raw;
                end else if (m_dc[i] + 1 >= int'(m_dead)) begin
                    m_pos[i] = m_lvl[i]; m_neg[i] = !m_lvl[i];
                end else m_dc[i]++;
            end
            if (!t_run) for (int i = 0; i < 3; i++) begin m_b2[i] = m_b1[i]; m_wk[i] = m_b1[i]; end
            else if (t_tp) begin
                if (m_ctrl[1]) for (int i = 0; i < 3; i++) begin m_wk[i] = m_b2[i]; m_b2[i] = m_b1[i]; end
                else for (int i = 0; i < 3; i++) m_wk[i] = m_b1[i];
            end
            if (!t_run) begin m_cnt = m_dead; m_up = 1; end
            else if (t_crest) begin m_up = 0; m_cnt = m_cnt - 1; end
            else if (t_trough) begin m_up = 1; m_cnt = 1; end
            else m_cnt = m_up ? m_cnt + 1 : m_cnt - 1;
            m_wrote = wr_en && wr_addr == 3'd7;
            if (wr_en) case (wr_addr)
                3'd0: m_ctrl = wr_data[4:0];
                3'd1: m_per = wr_data;
                3'd2: m_dead = wr_data;
                3'd3: m_adc = wr_data;
                3'd4: begin m_skcfg_c = wr_data[2:0]; m_skcfg_t = wr_data[5:3]; end
                default: m_b1[wr_addr - 5] = wr_data;
            endcase
        end
    end

    // ---------------- comparison and counting at negedge ----------------
    bit cmp_on = 0;
    int mm_pwm = 0, mm_cr = 0, mm_tr = 0, mm_adc = 0, n_overlap = 0;
    int c_cr = 0, c_tr = 0, c_adc = 0;

    always @(negedge clk) if (rst_n && cmp_on) begin
        if (pwm_pos !== m_pos || pwm_neg !== m_neg) mm_pwm++;
        if (crest_irq !== m_ci) mm_cr++;
        if (trough_irq !== m_ti) mm_tr++;
        if (adc_trig !== m_at) mm_adc++;
        if ((pwm_pos & pwm_neg & {3{m_ctrl[0]}}) != 0) n_overlap++;
        c_cr  += int'(crest_irq);
        c_tr  += int'(trough_irq);
        c_adc += int'(adc_trig);
    end

    task automatic clr();
        mm_pwm = 0; mm_cr = 0; mm_tr = 0; mm_adc = 0; n_overlap = 0;
        c_cr = 0; c_tr = 0; c_adc = 0;
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1; wr_addr = 3'(a); wr_data = 8'(d);
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic setup(input int per, input int dt, input int ctrl_stop);
        wr(0, ctrl_stop); wr(1, per); wr(2, dt);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++; n_tests++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        idle(3);
        // R1: reset state
        chk("R1 pos", int'(pwm_pos), 0);
        chk("R1 neg", int'(pwm_neg), 0);
        chk("R1 irq", int'({crest_irq, trough_irq, adc_trig}), 0);
        @(negedge clk); rst_n = 1; idle(2);
        chk("R1 after release", int'({pwm_pos, pwm_neg, crest_irq, trough_irq, adc_trig}), 0);
        cmp_on = 1;

        // R11 R12: idle level walk while stopped
        for (int v = 0; v < 4; v++) begin
            wr(0, v << 2); idle(1);
            chk("R11 idle pos", int'(pwm_pos), (v & 1) ? 7 : 0);
            chk("R12 idle neg bit", int'(pwm_neg), (v & 2) ? 7 : 0);
        end

        // R3 R4 R5 R6: dead band x buffer depth sweep
        for (int dt = 0; dt < 4; dt++) begin
            for (int db = 0; db < 2; db++) begin
                setup(12, dt, db << 1);
                wr(3, 4); wr(4, 0);
                wr(5, 0); wr(6, 5); wr(7, 12);
                idle(3); clr();
                wr(0, (db << 1) | 1);
                idle(40); wr(6, 8); wr(5, 3);
                idle(60); wr(7, 7);
                idle(50); wr(0, (db << 1) | 4);
                idle(4);
                chk("R3 leg levels", mm_pwm, 0);
                chk("R4 no overlap", n_overlap, 0);
                chk(db ? "R6 double buffer timing" : "R5 single buffer timing", mm_pwm, 0);
                chk("R2 crest/trough pulses", mm_cr + mm_tr, 0);
                chk("R11 stop to idle", int'(pwm_pos), 7);
            end
        end

        // R8 R9 R10: skip split sweep
        for (int n = 0; n < 8; n++) begin
            setup(12, 2, 0);
            wr(3, 3); wr(4, ((7 - n) << 3) | n);
            wr(5, 6); wr(6, 6); wr(7, 6);
            idle(3); clr();
            wr(0, 1);
            idle(194);
            wr(0, 0);
            idle(4);
            chk("R8 crest passes", c_cr, (8 + n) / (n + 1));
            chk("R9 trough passes", c_tr, (8 + (7 - n)) / (8 - n));
            chk("R10 adc passes", c_adc, (8 + (7 - n)) / (8 - n));
            chk("R10 adc timing", mm_adc, 0);
            chk("R8 R9 pulse timing", mm_cr + mm_tr, 0);
        end

        // R7: write-triggered transfer
        setup(12, 1, 16);
        wr(3, 0); wr(4, 0);
        wr(5, 2); wr(6, 6); wr(7, 10);
        idle(3); clr();
        wr(0, 17);
        idle(30); wr(5, 9); wr(6, 1);
        idle(60); wr(7, 4);
        idle(60); wr(0, 16);
        idle(4);
        chk("R7 write-trigger transfer", mm_pwm, 0);
        chk("R7 irq unaffected", mm_cr + mm_tr + mm_adc, 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule